// File: doc/BRIEF.md
# Router Address Lookup Table

This block turns the leading address byte of each packet into a forwarding decision for an 11-port packet router. Port 0 is the router's internal configuration port, ports 1 to 10 are the external ports (eight serial links and two parallel host ports). For every lookup strobe the block answers, one clock later, with a bitmask of the output ports the packet may leave through, a priority flag, a header-strip flag and a discard request.

Address bytes fall into three classes. Small values name a port directly. A band of values just above them is reserved and always spilled. The remaining values are logical addresses, resolved through a programmable table whose entries each hold a set of candidate ports (so the crossbar can pick among them adaptively), a two-level priority and a flag that asks for the leading address byte to be removed before forwarding. Every logical entry starts out unusable after reset and stays so until the configuration logic writes a non-empty port set into it through the write/read port.

Top module: `route_lookup`

## Requirements
- R1: After a synchronous reset every logical entry (address 32 to 255) is invalid: a lookup of it returns discard=1 with an all-zero port mask, priority 0 and strip 0, and a configuration read of it returns all zeros.
- R2: A lookup of address 0 returns a port mask with only bit 0 set (bit k of the mask stands for port k), priority 0, strip 1 and discard 0, whatever the table holds.
- R3: A lookup of an address n from 1 to 10 returns a port mask with only bit n set, priority 0, strip 1 and discard 0.
- R4: A lookup of an address from 11 to 31 returns discard=1, an all-zero mask, priority 0 and strip 0.
- R5: A lookup of a logical address whose entry holds a non-empty mask returns that mask with the stored priority and strip flags and discard 0.
- R6: Writing an entry with an empty port mask makes it invalid again: later lookups return discard=1 with zero mask and flags, and configuration reads return zeros.
- R7: The lookup result and a lookup-valid flag appear on the clock edge after the strobe; lookup-valid is low in every other cycle, and the result outputs keep their value until the next strobe, even if the entry is rewritten meanwhile.
- R8: A configuration read returns {priority, strip, mask} of the addressed entry with a read-valid flag one clock later; writes to addresses below 32 are ignored and reads of them return zeros.
- R9: A lookup in the same cycle as a write to the same entry returns the contents from before that write; the next lookup sees the new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_req | input | 1 | Lookup strobe |
| lk_addr | input | 8 | Leading address byte to resolve |
| lk_valid | output | 1 | Result valid, one cycle after lk_req |
| lk_ports | output | 11 | Allowed output ports, bit k = port k |
| lk_prio | output | 1 | High-priority flag |
| lk_strip | output | 1 | Remove the leading address byte before forwarding |
| lk_discard | output | 1 | Spill the packet |
| cfg_wr | input | 1 | Entry write strobe |
| cfg_rd | input | 1 | Entry read strobe |
| cfg_addr | input | 8 | Logical address of the entry to access |
| cfg_wmask | input | 11 | Port set to write; zero invalidates |
| cfg_wprio | input | 1 | Priority flag to write |
| cfg_wstrip | input | 1 | Strip flag to write |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| cfg_rmask | output | 11 | Port set read back |
| cfg_rprio | output | 1 | Priority flag read back |
| cfg_rstrip | output | 1 | Strip flag read back |

## Verification
The bench sweeps all 256 address values after reset, after filling the table with a computed pattern and after invalidating a fifth of it, so the class boundaries at 10/11 and 31/32 are hit from both sides; an off-by-one in the decoder would forward a reserved address or spill a port address. Entries written with an empty mask must spill, which catches a design that keeps a valid bit set whenever any write happens. A write and a lookup to the same entry in one cycle must return the old contents, and a rewrite between strobes must not disturb the held result; a design with write-through or an unqualified output register would show the new value early. Writes aimed below address 32 must leave both the read-back and the port-address decode untouched, which exposes a table that aliases low addresses onto its entries.

// File: rtl/route_lookup_pkg.sv
package route_lookup_pkg;
  typedef enum logic [1:0] {
    CLS_PHYS  = 2'd0,
    CLS_RSVD  = 2'd1,
    CLS_LOGIC = 2'd2
  } addr_cls_t;
endpackage

// File: rtl/route_addr_class.sv
module route_addr_class
  import route_lookup_pkg::*;
#(
  parameter int AW       = 8,
  parameter int NPORTS   = 11,
  parameter int LOG_BASE = 32,
  parameter int IDXW     = 8
) (
  input  logic [AW-1:0]   addr,
  output addr_cls_t       cls,
  output logic [IDXW-1:0] idx
);
  localparam logic [AW-1:0] PHYS_LAST = AW'(NPORTS - 1);
  localparam logic [AW-1:0] LOG_FIRST = AW'(LOG_BASE);

  logic [AW-1:0] offs;

  always_comb begin
    offs = addr - LOG_FIRST;
    idx  = IDXW'(offs);
    if (addr <= PHYS_LAST)      cls = CLS_PHYS;
    else if (addr < LOG_FIRST)  cls = CLS_RSVD;
    else                        cls = CLS_LOGIC;
  end
endmodule

// File: rtl/route_entry_ram.sv
module route_entry_ram #(
  parameter int DW    = 13,
  parameter int DEPTH = 224,
  parameter int IDXW  = 8
) (
  input  logic            clk,
  input  logic            we,
  input  logic [IDXW-1:0] waddr,
  input  logic [DW-1:0]   wdata,
  input  logic            re,
  input  logic [IDXW-1:0] raddr,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/route_valid_bits.sv
module route_valid_bits #(
  parameter int DEPTH = 224,
  parameter int IDXW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IDXW-1:0] waddr,
  input  logic            wfill,
  input  logic            re_a,
  input  logic [IDXW-1:0] raddr_a,
  output logic            rvld_a,
  input  logic            re_b,
  input  logic [IDXW-1:0] raddr_b,
  output logic            rvld_b
);
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else if (we) begin
      vld[waddr] <= wfill;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvld_a <= 1'b0;
      rvld_b <= 1'b0;
    end else begin
      if (re_a) rvld_a <= vld[raddr_a];
      if (re_b) rvld_b <= vld[raddr_b];
    end
  end

  AST_EMPTY_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (we && !wfill) |=> !vld[$past(waddr)]); // R6
  AST_FULL_WRITE_SETS: assert property (@(posedge clk) disable iff (rst)
    (we && wfill) |=> vld[$past(waddr)]); // R5
endmodule

// File: rtl/route_lookup.sv
module route_lookup
  import route_lookup_pkg::*;
#(
  parameter int AW       = 8,
  parameter int NPORTS   = 11,
  parameter int LOG_BASE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_req,
  input  logic [AW-1:0]     lk_addr,
  output logic              lk_valid,
  output logic [NPORTS-1:0] lk_ports,
  output logic              lk_prio,
  output logic              lk_strip,
  output logic              lk_discard,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [NPORTS-1:0] cfg_wmask,
  input  logic              cfg_wprio,
  input  logic              cfg_wstrip,
  output logic              cfg_rvalid,
  output logic [NPORTS-1:0] cfg_rmask,
  output logic              cfg_rprio,
  output logic              cfg_rstrip
);
  localparam int DEPTH = (1 << AW) - LOG_BASE;
  localparam int IDXW  = $clog2(DEPTH);
  localparam int DW    = NPORTS + 2;
  localparam logic [AW-1:0] PHYS_LAST = AW'(NPORTS - 1);
  localparam logic [AW-1:0] LOG_FIRST = AW'(LOG_BASE);

  addr_cls_t       lk_cls, cf_cls;
  logic [IDXW-1:0] lk_idx, cf_idx;

  route_addr_class #(.AW(AW), .NPORTS(NPORTS), .LOG_BASE(LOG_BASE), .IDXW(IDXW)) u_lk_class (
    .addr(lk_addr), .cls(lk_cls), .idx(lk_idx)
  );
  route_addr_class #(.AW(AW), .NPORTS(NPORTS), .LOG_BASE(LOG_BASE), .IDXW(IDXW)) u_cf_class (
    .addr(cfg_addr), .cls(cf_cls), .idx(cf_idx)
  );

  logic          tbl_we, lk_re, cf_re;
  logic [DW-1:0] tbl_wdata;

  assign tbl_we    = cfg_wr && (cf_cls == CLS_LOGIC);
  assign lk_re     = lk_req && (lk_cls == CLS_LOGIC);
  assign cf_re     = cfg_rd && (cf_cls == CLS_LOGIC);
  assign tbl_wdata = {cfg_wprio, cfg_wstrip, cfg_wmask};

  logic [DW-1:0]   rd_data [2];
  logic            rd_en   [2];
  logic [IDXW-1:0] rd_addr [2];

  assign rd_en[0]   = lk_re;
  assign rd_addr[0] = lk_idx;
  assign rd_en[1]   = cf_re;
  assign rd_addr[1] = cf_idx;

  for (genvar g = 0; g < 2; g++) begin : g_copy
    route_entry_ram #(.DW(DW), .DEPTH(DEPTH), .IDXW(IDXW)) u_ram (
      .clk(clk), .we(tbl_we), .waddr(cf_idx), .wdata(tbl_wdata),
      .re(rd_en[g]), .raddr(rd_addr[g]), .rdata(rd_data[g])
    );
  end

  logic lk_vld_q, cf_vld_q;

  route_valid_bits #(.DEPTH(DEPTH), .IDXW(IDXW)) u_valid (
    .clk(clk), .rst(rst),
    .we(tbl_we), .waddr(cf_idx), .wfill(|cfg_wmask),
    .re_a(lk_re), .raddr_a(lk_idx), .rvld_a(lk_vld_q),
    .re_b(cf_re), .raddr_b(cf_idx), .rvld_b(cf_vld_q)
  );

  addr_cls_t         lk_cls_q;
  logic [NPORTS-1:0] lk_phys_q;
  logic              lk_v_q, cf_rv_q, cf_logic_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_v_q     <= 1'b0;
      lk_cls_q   <= CLS_RSVD;
      lk_phys_q  <= '0;
      cf_rv_q    <= 1'b0;
      cf_logic_q <= 1'b0;
    end else begin
      lk_v_q  <= lk_req;
      cf_rv_q <= cfg_rd;
      if (lk_req) begin
        lk_cls_q  <= lk_cls;
        lk_phys_q <= NPORTS'(1) << lk_addr;
      end
      if (cfg_rd) cf_logic_q <= (cf_cls == CLS_LOGIC);
    end
  end

  always_comb begin
    lk_ports   = '0;
    lk_prio    = 1'b0;
    lk_strip   = 1'b0;
    lk_discard = 1'b1;
    case (lk_cls_q)
      CLS_PHYS: begin
        lk_ports   = lk_phys_q;
        lk_strip   = 1'b1;
        lk_discard = 1'b0;
      end
      CLS_LOGIC: begin
        if (lk_vld_q) begin
          lk_ports   = rd_data[0][NPORTS-1:0];
          lk_strip   = rd_data[0][NPORTS];
          lk_prio    = rd_data[0][NPORTS+1];
          lk_discard = 1'b0;
        end
      end
      default: ;
    endcase
  end

  assign lk_valid   = lk_v_q;
  assign cfg_rvalid = cf_rv_q;

  always_comb begin
    cfg_rmask  = '0;
    cfg_rprio  = 1'b0;
    cfg_rstrip = 1'b0;
    if (cf_logic_q && cf_vld_q) begin
      cfg_rmask  = rd_data[1][NPORTS-1:0];
      cfg_rstrip = rd_data[1][NPORTS];
      cfg_rprio  = rd_data[1][NPORTS+1];
    end
  end

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_valid); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_valid); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> ($stable(lk_ports) && $stable(lk_discard) && $stable(lk_prio))); // R7
  AST_CFG_PORT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (lk_req && lk_addr == '0) |=> (lk_ports == NPORTS'(1) && !lk_discard)); // R2
  AST_PHYS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (lk_req && lk_addr != '0 && lk_addr <= PHYS_LAST)
      |=> ($countones(lk_ports) == 1 && lk_strip && !lk_prio && !lk_discard)); // R3
  AST_RESERVED_SPILL: assert property (@(posedge clk) disable iff (rst)
    (lk_req && lk_addr > PHYS_LAST && lk_addr < LOG_FIRST)
      |=> (lk_discard && lk_ports == '0)); // R4
  AST_FORWARD_HAS_PORT: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_discard) |-> (lk_ports != '0)); // R5
  AST_READ_NEXT: assert property (@(posedge clk) disable iff (rst)
    cfg_rd |=> cfg_rvalid); // R8
endmodule

// File: tb/route_lookup_tb.sv
`timescale 1ns/1ps
module route_lookup_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_req;
  logic [7:0]  lk_addr;
  logic        lk_valid;
  logic [10:0] lk_ports;
  logic        lk_prio, lk_strip, lk_discard;
  logic        cfg_wr, cfg_rd;
  logic [7:0]  cfg_addr;
  logic [10:0] cfg_wmask;
  logic        cfg_wprio, cfg_wstrip;
  logic        cfg_rvalid;
  logic [10:0] cfg_rmask;
  logic        cfg_rprio, cfg_rstrip;

  route_lookup u_dut (
    .clk(clk), .rst(rst),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_valid(lk_valid), .lk_ports(lk_ports),
    .lk_prio(lk_prio), .lk_strip(lk_strip), .lk_discard(lk_discard),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_wmask(cfg_wmask),
    .cfg_wprio(cfg_wprio), .cfg_wstrip(cfg_wstrip), .cfg_rvalid(cfg_rvalid),
    .cfg_rmask(cfg_rmask), .cfg_rprio(cfg_rprio), .cfg_rstrip(cfg_rstrip)
  );

  always #10 clk = ~clk;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  logic [10:0] m_mask  [256];
  logic        m_prio  [256];
  logic        m_strip [256];

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {valid, discard, prio, strip, mask}
  function automatic logic [14:0] exp_lookup(input int a);
    if (a <= 10)                 return {1'b1, 1'b0, 1'b0, 1'b1, 11'(1 << a)};
    else if (a < 32)             return {1'b1, 1'b1, 1'b0, 1'b0, 11'd0};
    else if (m_mask[a] != 11'd0) return {1'b1, 1'b0, m_prio[a], m_strip[a], m_mask[a]};
    else                         return {1'b1, 1'b1, 1'b0, 1'b0, 11'd0};
  endfunction

  function automatic logic [12:0] exp_read(input int a);
    if (a < 32 || m_mask[a] == 11'd0) return 13'd0;
    return {m_prio[a], m_strip[a], m_mask[a]};
  endfunction

  function automatic string tag_of(input int a);
    if (a == 0)       return "R2";
    else if (a <= 10) return "R3";
    else if (a < 32)  return "R4";
    else              return "R5/R1/R6";
  endfunction

  task automatic lookup(input int a, output logic [14:0] got);
    @(negedge clk);
    lk_req = 1'b1; lk_addr = 8'(a);
    @(negedge clk);
    lk_req = 1'b0;
    got = {lk_valid, lk_discard, lk_prio, lk_strip, lk_ports};
  endtask

  task automatic cfg_write(input int a, input logic [10:0] m, input logic p, input logic s);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'(a); cfg_wmask = m; cfg_wprio = p; cfg_wstrip = s;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input int a, output logic [13:0] got);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = 8'(a);
    @(negedge clk);
    cfg_rd = 1'b0;
    got = {cfg_rvalid, cfg_rprio, cfg_rstrip, cfg_rmask};
  endtask

  task automatic sweep_lookup(input string phase);
    logic [14:0] got;
    for (int a = 0; a < 256; a++) begin
      lookup(a, got);
      check(got == exp_lookup(a), {tag_of(a), " ", phase}, 16'(got), 16'(exp_lookup(a)));
    end
  endtask

  task automatic sweep_read(input string phase);
    logic [13:0] got;
    for (int a = 0; a < 256; a++) begin
      cfg_read(a, got);
      check(got == {1'b1, exp_read(a)}, {"R8 ", phase}, 16'(got), 16'({1'b1, exp_read(a)}));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [14:0] lg;
    logic [13:0] rg;
    rst = 1'b1; lk_req = 1'b0; lk_addr = '0; cfg_wr = 1'b0; cfg_rd = 1'b0;
    cfg_addr = '0; cfg_wmask = '0; cfg_wprio = 1'b0; cfg_wstrip = 1'b0;
    for (int a = 0; a < 256; a++) begin m_mask[a] = '0; m_prio[a] = 1'b0; m_strip[a] = 1'b0; end
    repeat (4) @(negedge clk);
    check(lk_valid == 1'b0 && cfg_rvalid == 1'b0, "R1 reset flags", 16'({lk_valid, cfg_rvalid}), 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check(lk_valid == 1'b0, "R7 idle after reset", 16'(lk_valid), 16'd0);

    sweep_lookup("after reset");
    sweep_read("after reset");

    for (int a = 32; a < 256; a++) begin
      m_mask[a]  = (a % 16 == 0) ? 11'd0 : 11'((a * 37 + 5) % 2048);
      m_prio[a]  = a[0];
      m_strip[a] = a[1];
      cfg_write(a, m_mask[a], m_prio[a], m_strip[a]);
    end
    cfg_write(5, 11'h7FF, 1'b1, 1'b0);
    cfg_write(20, 11'h155, 1'b1, 1'b1);
    sweep_lookup("after fill");
    sweep_read("after fill");

    for (int a = 32; a < 256; a += 5) begin
      m_mask[a] = 11'd0;
      cfg_write(a, 11'd0, 1'b1, 1'b1);
    end
    sweep_lookup("after invalidate R6");
    sweep_read("after invalidate R6");

    // R7: result holds while the entry is rewritten between strobes
    lookup(33, lg);
    check(lg == exp_lookup(33), "R7 base", 16'(lg), 16'(exp_lookup(33)));
    cfg_write(33, 11'h003, 1'b0, 1'b0);
    check({lk_valid, lk_discard, lk_prio, lk_strip, lk_ports} == {1'b0, lg[13:0]},
          "R7 hold", 16'({lk_valid, lk_discard, lk_prio, lk_strip, lk_ports}), 16'({1'b0, lg[13:0]}));
    m_mask[33] = 11'h003; m_prio[33] = 1'b0; m_strip[33] = 1'b0;
    lookup(33, lg);
    check(lg == exp_lookup(33), "R7 refreshed", 16'(lg), 16'(exp_lookup(33)));

    // R9: same-cycle write and lookup of one entry
    @(negedge clk);
    lk_req = 1'b1; lk_addr = 8'd34;
    cfg_wr = 1'b1; cfg_addr = 8'd34; cfg_wmask = 11'h400; cfg_wprio = 1'b1; cfg_wstrip = 1'b1;
    @(negedge clk);
    lk_req = 1'b0; cfg_wr = 1'b0;
    lg = {lk_valid, lk_discard, lk_prio, lk_strip, lk_ports};
    check(lg == exp_lookup(34), "R9 old contents", 16'(lg), 16'(exp_lookup(34)));
    m_mask[34] = 11'h400; m_prio[34] = 1'b1; m_strip[34] = 1'b1;
    lookup(34, lg);
    check(lg == exp_lookup(34), "R9 new contents", 16'(lg), 16'(exp_lookup(34)));
    cfg_read(34, rg);
    check(rg == {1'b1, exp_read(34)}, "R8 after collision", 16'(rg), 16'({1'b1, exp_read(34)}));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule